// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Event Detection

This block controls a set of general-purpose pins (sixteen by default) from a simple 32-bit register bus. Software sets the value each pin drives and whether the pin drives at all. It can also read back the pins' sampled levels. The pad ring takes the drive value and an output enable straight from the block. Every pin is sampled through its own two-flop synchronizer, whatever its direction.

Each pin has a 3-bit detection code. The code selects one of five conditions: active-high level, active-low level, rising edge, falling edge, or any change. When the condition occurs, the pin's status bit is set. Level-mode status bits follow the synchronized level from cycle to cycle. Edge-mode status bits stay set until software writes a 1 to them. Each status bit drives one interrupt line, and the interrupt controller collects these lines.

Register offsets on the byte-addressed bus are fixed, because driver software decodes them:

| Offset | Contents |
|---|---|
| 0x00 | drive values |
| 0x04 | direction |
| 0x08 | synchronized input levels |
| 0x0C | status |
| 0x10 | detection codes for pins 0 to 7 |
| 0x14 | detection codes for pins 8 to 15 |

A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the following hold. The drive register is 0. Every direction bit is 1, so `pad_oe` is 0. Both code registers are 0. Every status bit is 0.
- R2: A write to offset 0x00 stores the low 16 bits of write data. `pad_out` shows them from the next cycle. Reads of 0x00 return them with bits 31:16 zero.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. Direction is written and read at offset 0x04. `pad_oe` is the bitwise inverse of the direction register.
- R4: Offset 0x08 returns `pad_in` through two flops. A value applied before clock edge k can be read after edge k+1 and not after edge k alone.
- R5: The code for pin p sits at bits 3·(p mod 8)+2 : 3·(p mod 8). Pins 0 to 7 use the register at 0x10, and pins 8 to 15 use the register at 0x14. Bits 31:24 of both registers read as zero.
- R6: Code 0 (active-high level): after each clock edge, the status bit equals the synchronized level that was present before that edge. It is not latched.
- R7: Code 1 (active-low level): after each clock edge, the status bit equals the inverse of the synchronized level that was present before that edge.
- R8: Code 2 (rising edge): a 0→1 change of the synchronized level sets the status bit. The bit stays set until a write to 0x0C with a 1 in that bit position.
- R9: Code 3 (falling edge): a 1→0 change of the synchronized level sets the status bit. The bit is cleared by write-one-to-clear, as in R8.
- R10: Code 4 (any change): either change of the synchronized level sets the status bit. The bit is cleared by write-one-to-clear.
- R11: Codes 5, 6 and 7 disable detection. The status bit for such a pin is 0 one cycle after the code is in place and stays 0 whatever the pin does.
- R12: If a write-one-to-clear and a qualifying edge fall in the same cycle for the same pin, the bit stays set. A write of 0 to a bit, or a write to a bit in a level mode, has no effect.
- R13: `irq_o` equals the status register bit for bit. A read from any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Pin drive values |
| pad_oe | output | 16 | Pin drive enables, 1 = drive |
| irq_o | output | 16 | Per-pin interrupt requests |

## Verification
Two things can hit the same edge-mode status bit in the same cycle: software's write-one-to-clear and a newly detected edge. The bench sets this up on purpose. It latches a bit in any-change mode, then drops the pin. It times the clearing write so that the bus strobe lands on the clock edge where the synchronized fall is first compared. The bit must still read 1. In the same write, a neighbouring rising-edge pin that has no new event must clear. The sweep rotates every code across every pin. It compares status and `irq_o` against a model in the bench after each input pattern and after partial clears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Detection codes. Codes 5..7 disable detection.
  typedef enum logic [2:0] {
    DET_HIGH = 3'd0,
    DET_LOW  = 3'd1,
    DET_RISE = 3'd2,
    DET_FALL = 3'd3,
    DET_ANY  = 3'd4
  } det_mode_e;

  localparam int MODE_W        = 3;
  localparam int PINS_PER_TYPE = 8;
  localparam int TYPE_BITS     = MODE_W * PINS_PER_TYPE;

  // Byte offsets on the register bus.
  localparam int OFS_OUT  = 'h00;
  localparam int OFS_DIR  = 'h04;
  localparam int OFS_IN   = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_TYPE = 'h10;

  // Bit position of a pin's code inside its code register.
  function automatic int mode_lsb(int pin);
    return MODE_W * (pin % PINS_PER_TYPE);
  endfunction

  // Index of the code register that holds a pin.
  function automatic int type_reg_of(int pin);
    return pin / PINS_PER_TYPE;
  endfunction

  // 1 for the three edge-latching codes.
  function automatic logic is_edge_mode(logic [MODE_W-1:0] m);
    return (m == DET_RISE) || (m == DET_FALL) || (m == DET_ANY);
  endfunction

  // 1 when the event selected by the code is present this cycle.
  function automatic logic edge_hit(logic [MODE_W-1:0] m, logic cur, logic prev);
    logic r;
    r = 1'b0;
    case (m)
      DET_RISE: r = cur & ~prev;
      DET_FALL: r = ~cur & prev;
      DET_ANY:  r = cur ^ prev;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  // Two flops per pin, then a third that holds last cycle's synchronized value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_o == $past(sync_o)));

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cur_i,
  input  logic              prev_i,
  input  logic              clr_i,
  output logic              stat_o
);

  logic stat_q;
  logic stat_d;
  logic evt_hit;
  logic edge_mode;
  logic disabled;

  // Internal events, named so the assertions can refer to them.
  assign evt_hit   = edge_hit(mode_i, cur_i, prev_i);
  assign edge_mode = is_edge_mode(mode_i);
  assign disabled  = (mode_i > DET_ANY);

  always_comb begin
    case (mode_i)
      DET_HIGH: stat_d = cur_i;
      DET_LOW:  stat_d = ~cur_i;
      DET_RISE,
      DET_FALL,
      DET_ANY:  stat_d = (stat_q & ~clr_i) | evt_hit;
      default:  stat_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R6
  level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_HIGH) |=> (stat_o == $past(cur_i)));

  // R7
  level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_LOW) |=> (stat_o == !$past(cur_i)));

  // R8
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_RISE && cur_i && !prev_i) |=> stat_o);

  // R9
  fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_FALL && !cur_i && prev_i) |=> stat_o);

  // R10
  any_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_ANY && (cur_i != prev_i)) |=> stat_o);

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && stat_o && !clr_i) |=> stat_o);

  // R8
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr_i && !evt_hit) |=> !stat_o);

  // R11
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> !stat_o);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_hit) |=> stat_o);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] irq_o
);

  localparam int NTYPE = (NUM_PINS + PINS_PER_TYPE - 1) / PINS_PER_TYPE;

  logic [NUM_PINS-1:0]  out_q;
  logic [NUM_PINS-1:0]  dir_q;
  logic [TYPE_BITS-1:0] type_q [NTYPE];
  logic [NUM_PINS-1:0]  in_sync;
  logic [NUM_PINS-1:0]  in_prev;
  logic [NUM_PINS-1:0]  stat_vec;
  logic [NUM_PINS-1:0]  clr_vec;
  logic                 wr_any;
  logic                 wr_out;
  logic                 wr_dir;
  logic                 wr_stat;
  logic                 unused_hi;

  assign wr_any  = bus_sel && bus_wr;
  assign wr_out  = wr_any && (bus_addr == ADDR_W'(OFS_OUT));
  assign wr_dir  = wr_any && (bus_addr == ADDR_W'(OFS_DIR));
  assign wr_stat = wr_any && (bus_addr == ADDR_W'(OFS_STAT));
  assign clr_vec = wr_stat ? bus_wdata[NUM_PINS-1:0] : '0;
  assign unused_hi = ^bus_wdata[DATA_W-1:TYPE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      if (wr_out) out_q <= bus_wdata[NUM_PINS-1:0];
      if (wr_dir) dir_q <= bus_wdata[NUM_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTYPE; i++) type_q[i] <= '0;
    end else begin
      for (int i = 0; i < NTYPE; i++) begin
        if (wr_any && bus_addr == ADDR_W'(OFS_TYPE + 4 * i))
          type_q[i] <= bus_wdata[TYPE_BITS-1:0];
      end
    end
  end

  gpio_in_sync #(.WIDTH(NUM_PINS)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (in_sync),
    .prev_o (in_prev)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_detect det_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (type_q[type_reg_of(p)][mode_lsb(p) +: MODE_W]),
      .cur_i  (in_sync[p]),
      .prev_i (in_prev[p]),
      .clr_i  (clr_vec[p]),
      .stat_o (stat_vec[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_OUT))  bus_rdata = DATA_W'(out_q);
    if (bus_addr == ADDR_W'(OFS_DIR))  bus_rdata = DATA_W'(dir_q);
    if (bus_addr == ADDR_W'(OFS_IN))   bus_rdata = DATA_W'(in_sync);
    if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = DATA_W'(stat_vec);
    for (int i = 0; i < NTYPE; i++) begin
      if (bus_addr == ADDR_W'(OFS_TYPE + 4 * i)) bus_rdata = DATA_W'(type_q[i]);
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq_o   = stat_vec;

  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> (pad_out == $past(bus_wdata[NUM_PINS-1:0])));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == ~$past(bus_wdata[NUM_PINS-1:0])));

  // R13
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_STAT)) |-> (bus_rdata[NUM_PINS-1:0] == irq_o));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;

  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [2:0]    mode_m [NP];
  logic [NP-1:0] exp_st;
  logic [NP-1:0] pad_m;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_now(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    read_now(a, d);
  endtask

  // Apply pins and wait past synchronizer and status flop.
  task automatic drive_pads(logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  // Model of status after one settled change of the pins.
  task automatic model_step(logic [NP-1:0] nv);
    for (int p = 0; p < NP; p++) begin
      case (mode_m[p])
        3'd0: exp_st[p] = nv[p];
        3'd1: exp_st[p] = !nv[p];
        3'd2: exp_st[p] = exp_st[p] | (nv[p] & !pad_m[p]);
        3'd3: exp_st[p] = exp_st[p] | (!nv[p] & pad_m[p]);
        3'd4: exp_st[p] = exp_st[p] | (nv[p] ^ pad_m[p]);
        default: exp_st[p] = 1'b0;
      endcase
    end
    pad_m = nv;
  endtask

  task automatic model_clear(logic [NP-1:0] m);
    for (int p = 0; p < NP; p++)
      if (mode_m[p] inside {3'd2, 3'd3, 3'd4} && m[p]) exp_st[p] = 1'b0;
  endtask

  task automatic check_status(string tag);
    logic [31:0] d;
    bus_read(5'h0C, d);
    check(tag, d, {16'h0, exp_st});
    check("R13 irq_o", {16'h0, irq_o}, {16'h0, exp_st});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] t0, t1;
    logic [NP-1:0] pats [5];
    pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h0F0F;
    pats[3] = 16'h0000; pats[4] = 16'h5A3C;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_now(5'h00, d); check("R1 out reg", d, 32'h0);
    read_now(5'h04, d); check("R1 dir reg", d, 32'h0000FFFF);
    read_now(5'h0C, d); check("R1 status", d, 32'h0);
    read_now(5'h10, d); check("R1 type1", d, 32'h0);
    read_now(5'h14, d); check("R1 type2", d, 32'h0);
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);

    // R2 drive register
    bus_write(5'h00, 32'h1234ABCD);
    check("R2 pad_out", {16'h0, pad_out}, 32'h0000ABCD);
    read_now(5'h00, d); check("R2 readback", d, 32'h0000ABCD);

    // R3 direction and output enable
    bus_write(5'h04, 32'hFFFF00F0);
    check("R3 pad_oe", {16'h0, pad_oe}, 32'h0000FF0F);
    read_now(5'h04, d); check("R3 readback", d, 32'h000000F0);

    // R5 code registers keep 24 bits
    bus_write(5'h10, 32'hFFFFFFFF);
    read_now(5'h10, d); check("R5 type1 width", d, 32'h00FFFFFF);
    bus_write(5'h14, 32'hDB000010);
    read_now(5'h14, d); check("R5 type2 width", d, 32'h00000010);

    // R13 unmapped offsets
    read_now(5'h18, d); check("R13 unmapped 0x18", d, 32'h0);
    read_now(5'h1C, d); check("R13 unmapped 0x1C", d, 32'h0);

    // R4 two-flop timing of the input readback
    @(negedge clk);
    pad_in = 16'hC3A5;
    @(negedge clk);
    read_now(5'h08, d); check("R4 not yet visible", d, 32'h0);
    @(negedge clk);
    read_now(5'h08, d); check("R4 visible after two edges", d, 32'h0000C3A5);
    drive_pads(16'h0000);

    // Sweep: every code on every pin (R6 R7 R8 R9 R10 R11)
    pad_m = '0;
    for (int r = 0; r < 8; r++) begin
      t0 = '0; t1 = '0;
      for (int p = 0; p < NP; p++) begin
        mode_m[p] = 3'((p + r) % 8);
        if (p < 8) t0[3*(p%8) +: 3] = mode_m[p];
        else       t1[3*(p%8) +: 3] = mode_m[p];
      end
      drive_pads(16'h0000);
      bus_write(5'h10, t0);
      bus_write(5'h14, t1);
      bus_write(5'h0C, 32'h0000FFFF);
      pad_m = '0;
      for (int p = 0; p < NP; p++) exp_st[p] = (mode_m[p] == 3'd1);
      check_status("R6 R7 R11 after mode load");
      for (int k = 0; k < 5; k++) begin
        drive_pads(pats[k]);
        model_step(pats[k]);
        check_status("R6 R7 R8 R9 R10 R11 sweep");
        if (k == 2) begin
          // R12 partial write-one-to-clear; zeros and level bits unaffected
          bus_write(5'h0C, 32'h000000FF);
          model_clear(16'h00FF);
          check_status("R8 R9 R10 R12 partial clear");
        end
      end
    end

    // R12 clear and new edge in the same cycle
    drive_pads(16'h0000);
    bus_write(5'h10, 32'h00000014);   // pin0 code 4, pin1 code 2
    bus_write(5'h14, 32'h00B6DB6D);   // pins 8..15 disabled (code 5)
    bus_write(5'h0C, 32'h0000FFFF);
    drive_pads(16'h0003);
    bus_read(5'h0C, d); check("R10 R8 both latched", d & 32'h3, 32'h3);
    @(negedge clk);
    pad_in = 16'h0002;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h3;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    read_now(5'h0C, d); check("R12 set wins over clear", d & 32'h3, 32'h1);
    check("R12 irq_o", {16'h0, irq_o} & 32'h3, 32'h1);

    finish_run();
  end

endmodule